// File: doc/BRIEF.md
# Peripheral On-Demand Oscillator Clock Gate

While the chip sits in its deepest stop state, the shared high-speed oscillator is powered down. Some peripherals, such as a serial receiver or a two-wire bus slave, can still wake the system. These peripherals must be able to bring the oscillator back for as long as it takes to receive one frame. This block handles those requests. Each wakeup-capable peripheral has a request line, a frame-done pulse and a flag that marks the frame as a wakeup frame.

The block picks one requester and enables the oscillator. It then waits until the oscillator's ready signal has been stable for a set number of cycles. Only then does it open a glitch-free clock-enable gate, and only for that one peripheral. At the end of the frame there are two outcomes:

- If the frame was not a wakeup frame, the block shuts the oscillator down again and the system stays stopped.
- If it was a wakeup frame, the block raises a system wakeup request and keeps the oscillator running.

The oscillator itself lies outside the block. It appears only as an enable output and a ready input.

Top module: `osc_demand_gate`

## Requirements
- R1: After reset, `osc_en`, every bit of `clk_en` and `wakeup` are low.
- R2: While `stop_mode` is low and the block is idle, requests are ignored: `osc_en` and `clk_en` stay low.
- R3: In the stop state, a request from an idle block drives `osc_en` high on the next clock edge.
- R4: `clk_en` stays low until `osc_rdy` has been sampled high on `RDY_CYCLES` consecutive edges (default 2). A low sample restarts the count. The gate opens on the edge of the last qualifying sample.
- R5: At most one bit of `clk_en` is high at any time, and it is the bit of the granted peripheral. Bit i of `clk_en`, `req`, `frame_done` and `wake_frame` all belong to peripheral i.
- R6: When several peripherals request together, the one with the lowest index is granted. The others wait until that frame has finished, and are then served.
- R7: A `frame_done` pulse from the granted peripheral with `wake_frame` low returns the block to idle on that edge: `osc_en` and `clk_en` drop, and `wakeup` stays low.
- R8: A `frame_done` pulse with `wake_frame` high closes the gate, raises `wakeup` and keeps `osc_en` high. Both stay in that state until `stop_mode` goes low, and then both drop on the next edge.
- R9: If the granted request is withdrawn before the ready qualification completes, the block returns to idle and `osc_en` drops on the next edge.
- R10: `frame_done` and `wake_frame` from a peripheral that is not granted have no effect.
- R11: Once the gate is open, the grant is held until the granted peripheral's `frame_done`, even if its request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_mode | input | 1 | High while the system is in the deep stop state |
| req | input | N_PERIPH | Per-peripheral oscillator request |
| frame_done | input | N_PERIPH | Per-peripheral end-of-frame pulse |
| wake_frame | input | N_PERIPH | Per-peripheral flag: the finished frame is a wakeup frame |
| osc_rdy | input | 1 | Oscillator ready from the analog macro |
| osc_en | output | 1 | Oscillator enable to the analog macro |
| clk_en | output | N_PERIPH | Registered per-peripheral clock-gate enables |
| wakeup | output | 1 | System wakeup request |

## Verification
The bench makes `osc_rdy` bounce low partway through qualification. A design that does not restart the count would open the gate one or more cycles too early. It makes two peripherals request at once and then withdraws the winner's request during its frame. This exposes a wrong priority order, and also a design that drops the grant or lets the waiting peripheral in early. It sends frame-done and wakeup-flag pulses from a peripheral that does not hold the grant. A design that does not qualify them by the grant would end the frame or wake the system by mistake. It also ends one frame as a wakeup frame and holds the wakeup state for several cycles. A design that shut the oscillator off or let `wakeup` lapse before `stop_mode` falls would be caught there.

// File: rtl/osc_gate_pkg.sv
package osc_gate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_RUN   = 2'd2,
      ST_WAKE  = 2'd3
   } gate_state_e;
endpackage

// File: rtl/osc_fixed_arb.sv
module osc_fixed_arb #(
   parameter int N_PERIPH = 4,
   localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
   input  logic [N_PERIPH-1:0] req,
   output logic [N_PERIPH-1:0] gnt,
   output logic [IDX_W-1:0]    gnt_idx,
   output logic                any_req
);
   // below[i] is high when some lower index is requesting
   logic [N_PERIPH:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < N_PERIPH; i++) begin : g_chain
      assign gnt[i]     = req[i] & ~below[i];
      assign below[i+1] = below[i] | req[i];
   end

   assign any_req = below[N_PERIPH];

   always_comb begin
      gnt_idx = '0;
      for (int i = N_PERIPH - 1; i >= 0; i--) begin
         if (req[i]) gnt_idx = IDX_W'(i);
      end
   end

   always_comb begin
      AST_ARB_ONEHOT: assert ($onehot0(gnt));                 // R6
   end
endmodule

// File: rtl/osc_ready_qual.sv
module osc_ready_qual #(
   parameter int RDY_CYCLES = 2,
   localparam int CNT_W = (RDY_CYCLES > 1) ? $clog2(RDY_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic osc_rdy,
   output logic qualified
);
   if (RDY_CYCLES < 1) begin : g_bad_cycles
      $error("osc_ready_qual: RDY_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   if (RDY_CYCLES == 1) begin : g_direct
      assign qualified = osc_rdy;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= '0;
      end
   end else begin : g_count
      assign qualified = osc_rdy && (cnt_q == CNT_W'(RDY_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (clear || !osc_rdy)    cnt_q <= '0;
         else if (!qualified)           cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_QUAL_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      qualified |-> osc_rdy);                                  // R4
endmodule

// File: rtl/osc_gate_bank.sv
module osc_gate_bank #(
   parameter int N_PERIPH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                open_gate,
   input  logic [N_PERIPH-1:0] sel,
   output logic [N_PERIPH-1:0] en_q
);
   // one flop per gate: enables leave the block straight from a register
   for (genvar i = 0; i < N_PERIPH; i++) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q[i] <= 1'b0;
         else        en_q[i] <= open_gate & sel[i];
      end
   end

   AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_q));                                         // R5
endmodule

// File: rtl/osc_demand_gate.sv
module osc_demand_gate
   import osc_gate_pkg::*;
#(
   parameter int N_PERIPH   = 4,
   parameter int RDY_CYCLES = 2,
   localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stop_mode,
   input  logic [N_PERIPH-1:0] req,
   input  logic [N_PERIPH-1:0] frame_done,
   input  logic [N_PERIPH-1:0] wake_frame,
   input  logic                osc_rdy,
   output logic                osc_en,
   output logic [N_PERIPH-1:0] clk_en,
   output logic                wakeup
);
   if (N_PERIPH < 1) begin : g_bad_n
      $error("osc_demand_gate: N_PERIPH must be at least 1");
   end

   gate_state_e          state_q, state_d;
   logic [IDX_W-1:0]     grant_q, grant_d;
   logic [N_PERIPH-1:0]  arb_gnt, grant_sel;
   logic [IDX_W-1:0]     arb_idx;
   logic                 any_req, rdy_ok;
   logic                 own_req, own_done, own_wake;

   osc_fixed_arb #(.N_PERIPH(N_PERIPH)) u_arb (
      .req     (req),
      .gnt     (arb_gnt),
      .gnt_idx (arb_idx),
      .any_req (any_req)
   );

   osc_ready_qual #(.RDY_CYCLES(RDY_CYCLES)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q != ST_START),
      .osc_rdy   (osc_rdy),
      .qualified (rdy_ok)
   );

   assign own_req  = req[grant_q];
   assign own_done = frame_done[grant_q];
   assign own_wake = wake_frame[grant_q];

   always_comb begin
      state_d = state_q;
      grant_d = grant_q;
      unique case (state_q)
         ST_IDLE: begin
            if (stop_mode && any_req) begin
               state_d = ST_START;
               grant_d = arb_idx;
            end
         end
         ST_START: begin
            if (!own_req)    state_d = ST_IDLE;
            else if (rdy_ok) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (own_done) state_d = own_wake ? ST_WAKE : ST_IDLE;
         end
         ST_WAKE: begin
            if (!stop_mode) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         grant_q <= '0;
      end else begin
         state_q <= state_d;
         grant_q <= grant_d;
      end
   end

   assign grant_sel = {{(N_PERIPH-1){1'b0}}, 1'b1} << grant_d;

   osc_gate_bank #(.N_PERIPH(N_PERIPH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_gate (state_d == ST_RUN),
      .sel       (grant_sel),
      .en_q      (clk_en)
   );

   assign osc_en = (state_q != ST_IDLE);
   assign wakeup = (state_q == ST_WAKE);

   AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      (|clk_en) |-> osc_en);                                   // R4
   AST_GATE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_START) && (state_d == ST_RUN)) |=> (clk_en != '0) && $past(osc_rdy)); // R4
   AST_IDLE_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_mode && !osc_en) |=> !osc_en);                    // R2
   AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !osc_en && any_req) |=> osc_en);           // R3
   AST_PLAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RUN) && own_done && !own_wake) |=> (!osc_en && clk_en == '0 && !wakeup)); // R7
   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wakeup && stop_mode) |=> (wakeup && osc_en && clk_en == '0)); // R8
   AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_START) && !own_req) |=> !osc_en);        // R9
   AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RUN) && !own_done) |=> ($stable(clk_en) && clk_en != '0)); // R11
endmodule

// File: tb/sim_osc_demand_gate.sv
module sim_osc_demand_gate;
   localparam int N  = 4;
   localparam int RC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         stop_mode = 1'b0;
   logic [N-1:0] req = '0, frame_done = '0, wake_frame = '0;
   logic         osc_rdy = 1'b0;
   logic         osc_en, wakeup;
   logic [N-1:0] clk_en;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   osc_demand_gate #(.N_PERIPH(N), .RDY_CYCLES(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .req(req),
      .frame_done(frame_done), .wake_frame(wake_frame), .osc_rdy(osc_rdy),
      .osc_en(osc_en), .clk_en(clk_en), .wakeup(wakeup)
   );

   // behavioural reference: 0 idle, 1 waiting for ready, 2 frame, 3 woken
   int m_st = 0, m_g = 0, m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_g = 0; m_cnt = 0;
      end else begin
         case (m_st)
            0: if (stop_mode && req != '0) begin
                  m_st = 1; m_cnt = 0;
                  for (int i = N - 1; i >= 0; i--) if (req[i]) m_g = i;
               end
            1: if (!req[m_g]) m_st = 0;
               else if (osc_rdy) begin
                  m_cnt++;
                  if (m_cnt >= RC) m_st = 2;
               end else m_cnt = 0;
            2: if (frame_done[m_g]) m_st = wake_frame[m_g] ? 3 : 0;
            default: if (!stop_mode) m_st = 0;
         endcase
      end
   end

   task automatic check(input string tag, input logic e_osc,
                        input logic [N-1:0] e_clk, input logic e_wk);
      checks++;
      if (osc_en !== e_osc || clk_en !== e_clk || wakeup !== e_wk) begin
         errors++;
         $display("FAIL %s: osc_en=%b clk_en=%b wakeup=%b expected %b %b %b",
                  tag, osc_en, clk_en, wakeup, e_osc, e_clk, e_wk);
      end
   endtask

   // model comparison on every cycle, away from the active edge (R5 one-hot gate)
   always @(negedge clk) begin
      if (rst_n) begin
         logic [N-1:0] e_clk;
         e_clk = (m_st == 2) ? (N'(1) << m_g) : '0;
         check("R5 model", m_st != 0, e_clk, m_st == 3);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check("R1 reset", 1'b0, '0, 1'b0);
      rst_n = 1'b1;
      step(1);
      check("R1 after release", 1'b0, '0, 1'b0);

      // R2: not stopped, request ignored
      req = 4'b0001;
      step(5);
      check("R2 ignored", 1'b0, '0, 1'b0);
      req = '0;

      // R3 / R4: ready bounce restarts qualification
      stop_mode = 1'b1; req = 4'b0100;
      step(1);
      check("R3 osc on", 1'b1, '0, 1'b0);
      step(3);
      check("R4 no ready", 1'b1, '0, 1'b0);
      osc_rdy = 1'b1; step(1);
      osc_rdy = 1'b0; step(1);
      check("R4 bounce", 1'b1, '0, 1'b0);
      osc_rdy = 1'b1; step(1);
      check("R4 one sample", 1'b1, '0, 1'b0);
      step(1);
      check("R4 gate open", 1'b1, 4'b0100, 1'b0);

      // R10: foreign frame_done / wake_frame ignored
      frame_done = 4'b0001; wake_frame = 4'b0001;
      step(1);
      frame_done = '0; wake_frame = '0;
      check("R10 foreign done", 1'b1, 4'b0100, 1'b0);

      // R7: plain frame ends, oscillator off
      frame_done = 4'b0100; req = '0;
      step(1);
      frame_done = '0;
      check("R7 shut down", 1'b0, '0, 1'b0);

      // R6 / R11: simultaneous requests, lowest wins, later one waits
      req = 4'b1010;
      step(3);
      check("R6 lowest first", 1'b1, 4'b0010, 1'b0);
      req = 4'b1000;
      step(2);
      check("R11 grant held", 1'b1, 4'b0010, 1'b0);
      frame_done = 4'b0010;
      step(1);
      frame_done = '0;
      check("R6 back to idle", 1'b0, '0, 1'b0);
      step(3);
      check("R6 waiter served", 1'b1, 4'b1000, 1'b0);
      frame_done = 4'b1000; req = '0;
      step(1);
      frame_done = '0;
      check("R7 second frame", 1'b0, '0, 1'b0);

      // R9: withdrawal before ready
      osc_rdy = 1'b0; req = 4'b0001;
      step(1);
      check("R9 started", 1'b1, '0, 1'b0);
      req = '0;
      step(1);
      check("R9 withdrawn", 1'b0, '0, 1'b0);

      // R8: wakeup frame
      osc_rdy = 1'b1; req = 4'b0100;
      step(3);
      check("R8 frame open", 1'b1, 4'b0100, 1'b0);
      frame_done = 4'b0100; wake_frame = 4'b0100; req = '0;
      step(1);
      frame_done = '0; wake_frame = '0;
      check("R8 wake raised", 1'b1, '0, 1'b1);
      step(4);
      check("R8 wake held", 1'b1, '0, 1'b1);
      stop_mode = 1'b0;
      step(1);
      check("R8 released", 1'b0, '0, 1'b0);
      step(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule